// File: doc/BRIEF.md
# Interrupt Entry Register Stacker

This block saves processor state to a byte-addressed stack when an interrupt is taken. An interrupt request is remembered until the interrupt mask bit is clear, and is then accepted. The block waits for the instruction in flight to complete, which the end-of-instruction strobe signals. It then flushes the instruction queue for one cycle and takes a snapshot of the return address, the register values and the stack pointer.

From that snapshot it writes a nine-byte frame through a 16-bit write port, one write per cycle. The frame is four 16-bit words followed by a single byte, and each word is written high byte first. When the frame is complete, the block presents the lowered stack pointer and raises a one-cycle completion strobe.

Vector fetch, instruction execution and unstacking on return lie outside this block.

Top module: `irq_stacker`

## Requirements
- R1: A synchronous reset leaves the block idle with no pending request. After reset `mem_we`, `q_flush` and `done` are low and `sp_o` is zero.
- R2: While `imask` is 1, a request is held pending and no flush or write occurs. Once `imask` is 0, the pending request is accepted, and an end-of-instruction strobe seen before acceptance has no effect.
- R3: After acceptance, nothing happens until `eoi` is sampled high. `q_flush` is then high in the following cycle only.
- R4: The flush cycle comes before any write. The five write cycles follow it back to back, starting the next cycle. The stack pointer and register values used are those present during the flush cycle.
- R5: Write port encoding: `mem_wdata[15:8]` is the byte at `mem_addr` and `mem_wdata[7:0]` is the byte at `mem_addr+1`. `mem_be[1]` enables the byte at `mem_addr` and `mem_be[0]` enables the byte at `mem_addr+1`. The first write stores the return address at SP-2 with `mem_be`=2'b11.
- R6: The second write stores Y at SP-4 and the third stores X at SP-6, both with `mem_be`=2'b11.
- R7: The fourth write stores the byte pair at SP-8, with B as the high data byte (lower address) and A as the low data byte, and `mem_be`=2'b11.
- R8: The fifth and last write stores the condition code byte at SP-9 in `mem_wdata[15:8]`, with `mem_be`=2'b10.
- R9: Addresses are computed modulo 2^SP_W, so a frame below a small stack pointer wraps to the top of the address space.
- R10: `done` is high for exactly one cycle, in the cycle after the last write. From that cycle on, `sp_o` holds the entry stack pointer minus 9 until the next frame ends.
- R11: A request that arrives while a frame is in progress is not accepted until `done` has been seen. An `eoi` during the frame is ignored. The deferred request then runs a complete new frame after a fresh `eoi`.
- R12: If a request is accepted in the same cycle that `eoi` is high, the flush follows in the next cycle without waiting for another strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | Interrupt request (a pulse is remembered) |
| imask | input | 1 | Interrupt mask; 1 blocks acceptance |
| eoi | input | 1 | End-of-instruction strobe |
| sp_i | input | SP_W | Current stack pointer |
| ret_i | input | WORD_W | Return address |
| idx_y_i | input | WORD_W | Y index register |
| idx_x_i | input | WORD_W | X index register |
| acc_b_i | input | BYTE_W | B accumulator |
| acc_a_i | input | BYTE_W | A accumulator |
| cond_i | input | BYTE_W | Condition code byte |
| mem_addr | output | SP_W | Write address (byte address of the high data byte) |
| mem_wdata | output | WORD_W | Write data |
| mem_be | output | 2 | Byte enables |
| mem_we | output | 1 | Write strobe |
| q_flush | output | 1 | Instruction queue flush |
| sp_o | output | SP_W | Updated stack pointer |
| done | output | 1 | Frame complete strobe |

## Verification
Acceptance of a request and the end-of-instruction strobe can fall in the same cycle. One directed case raises `irq_req` and `eoi` together with the mask clear, and it passes only if `q_flush` appears in the very next cycle. A second overlap comes from a new request and a stray `eoi` that arrive during the write cycles. That case is judged by the second flush appearing only after `done`, and only after a later `eoi`.

// File: rtl/irqstk_pkg.sv
package irqstk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_FLUSH,
      ST_WRITE,
      ST_DONE
   } stk_state_e;

   localparam int FRAME_SLOTS = 5;
   localparam int FRAME_BYTES = 9;

   // distance below the entry stack pointer for write slot k
   function automatic int slot_offset(input int k);
      return (k < FRAME_SLOTS - 1) ? 2 * (k + 1) : FRAME_BYTES;
   endfunction

   function automatic bit slot_is_word(input int k);
      return k < FRAME_SLOTS - 1;
   endfunction

endpackage

// File: rtl/irqstk_req.sv
module irqstk_req #(
   parameter int REQ_LATCH = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic irq,
   input  logic mask,
   input  logic idle,
   output logic accept_o
);

   generate
      if (REQ_LATCH != 0) begin : g_latched
         logic pend_q;
         assign accept_o = idle && !mask && (irq || pend_q);
         always_ff @(posedge clk) begin
            if (rst) pend_q <= 1'b0;
            else     pend_q <= (pend_q || irq) && !accept_o;
         end
      end else begin : g_level
         assign accept_o = idle && !mask && irq;
      end
   endgenerate

endmodule

// File: rtl/irqstk_seq.sv
module irqstk_seq
   import irqstk_pkg::*;
#(
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              eoi,
   output stk_state_e        st_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic              flush_o,
   output logic              we_o,
   output logic              last_o,
   output logic              done_o,
   output logic              idle_o
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

   stk_state_e        st_q;
   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         slot_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE:  if (accept) st_q <= eoi ? ST_FLUSH : ST_WAIT;
            ST_WAIT:  if (eoi) st_q <= ST_FLUSH;
            ST_FLUSH: begin
               st_q   <= ST_WRITE;
               slot_q <= '0;
            end
            ST_WRITE: begin
               if (slot_q == LAST_SLOT) st_q <= ST_DONE;
               else                     slot_q <= slot_q + 1'b1;
            end
            ST_DONE:  st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign st_o    = st_q;
   assign slot_o  = slot_q;
   assign idle_o  = (st_q == ST_IDLE);
   assign flush_o = (st_q == ST_FLUSH);
   assign we_o    = (st_q == ST_WRITE);
   assign last_o  = we_o && (slot_q == LAST_SLOT);
   assign done_o  = (st_q == ST_DONE);

endmodule

// File: rtl/irqstk_frame.sv
module irqstk_frame
   import irqstk_pkg::*;
#(
   parameter int SP_W   = 16,
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture,
   input  logic              commit,
   input  logic [SLOT_W-1:0] slot,
   input  logic [SP_W-1:0]   sp_i,
   input  logic [WORD_W-1:0] ret_i,
   input  logic [WORD_W-1:0] y_i,
   input  logic [WORD_W-1:0] x_i,
   input  logic [BYTE_W-1:0] b_i,
   input  logic [BYTE_W-1:0] a_i,
   input  logic [BYTE_W-1:0] cond_i,
   output logic [SP_W-1:0]   addr_o,
   output logic [WORD_W-1:0] data_o,
   output logic [1:0]        be_o,
   output logic [SP_W-1:0]   sp_o
);

   logic [SP_W-1:0]   snap_sp;
   logic [WORD_W-1:0] snap_ret, snap_y, snap_x;
   logic [BYTE_W-1:0] snap_b, snap_a, snap_cond;
   logic [SP_W-1:0]   sp_q;

   // snapshot taken in the flush cycle, before any write
   always_ff @(posedge clk) begin
      if (rst) begin
         snap_sp   <= '0;
         snap_ret  <= '0;
         snap_y    <= '0;
         snap_x    <= '0;
         snap_b    <= '0;
         snap_a    <= '0;
         snap_cond <= '0;
      end else if (capture) begin
         snap_sp   <= sp_i;
         snap_ret  <= ret_i;
         snap_y    <= y_i;
         snap_x    <= x_i;
         snap_b    <= b_i;
         snap_a    <= a_i;
         snap_cond <= cond_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         sp_q <= '0;
      else if (commit) sp_q <= snap_sp - SP_W'(FRAME_BYTES);
   end
   assign sp_o = sp_q;

   logic [SP_W-1:0]   s_addr [FRAME_SLOTS];
   logic [WORD_W-1:0] s_data [FRAME_SLOTS];
   logic [1:0]        s_be   [FRAME_SLOTS];

   generate
      for (genvar k = 0; k < FRAME_SLOTS; k++) begin : g_slot
         assign s_addr[k] = snap_sp - SP_W'(slot_offset(k));
         assign s_be[k]   = slot_is_word(k) ? 2'b11 : 2'b10;
         if (k == 0) begin : g_ret
            assign s_data[k] = snap_ret;
         end else if (k == 1) begin : g_y
            assign s_data[k] = snap_y;
         end else if (k == 2) begin : g_x
            assign s_data[k] = snap_x;
         end else if (k == 3) begin : g_acc
            assign s_data[k] = {snap_b, snap_a};
         end else begin : g_cond
            assign s_data[k] = {snap_cond, {BYTE_W{1'b0}}};
         end
      end
   endgenerate

   always_comb begin
      addr_o = '0;
      data_o = '0;
      be_o   = '0;
      for (int k = 0; k < FRAME_SLOTS; k++) begin
         if (slot == SLOT_W'(k)) begin
            addr_o = s_addr[k];
            data_o = s_data[k];
            be_o   = s_be[k];
         end
      end
   end

endmodule

// File: rtl/irq_stacker.sv
module irq_stacker
   import irqstk_pkg::*;
#(
   parameter int SP_W      = 16,
   parameter int BYTE_W    = 8,
   parameter int WORD_W    = 16,
   parameter int REQ_LATCH = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              irq_req,
   input  logic              imask,
   input  logic              eoi,
   input  logic [SP_W-1:0]   sp_i,
   input  logic [WORD_W-1:0] ret_i,
   input  logic [WORD_W-1:0] idx_y_i,
   input  logic [WORD_W-1:0] idx_x_i,
   input  logic [BYTE_W-1:0] acc_b_i,
   input  logic [BYTE_W-1:0] acc_a_i,
   input  logic [BYTE_W-1:0] cond_i,
   output logic [SP_W-1:0]   mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic [1:0]        mem_be,
   output logic              mem_we,
   output logic              q_flush,
   output logic [SP_W-1:0]   sp_o,
   output logic              done
);

   localparam int SLOT_W = $clog2(FRAME_SLOTS);

   generate
      if (WORD_W != 2 * BYTE_W) begin : g_bad_word
         $error("irq_stacker: WORD_W must be twice BYTE_W");
      end
      if (SP_W < 4) begin : g_bad_sp
         $error("irq_stacker: SP_W too narrow for the frame");
      end
   endgenerate

   stk_state_e        st;
   logic [SLOT_W-1:0] slot;
   logic              accept, idle, last_wr;

   irqstk_req #(.REQ_LATCH(REQ_LATCH)) u_req (
      .clk      (clk),
      .rst      (rst),
      .irq      (irq_req),
      .mask     (imask),
      .idle     (idle),
      .accept_o (accept)
   );

   irqstk_seq #(.SLOT_W(SLOT_W)) u_seq (
      .clk     (clk),
      .rst     (rst),
      .accept  (accept),
      .eoi     (eoi),
      .st_o    (st),
      .slot_o  (slot),
      .flush_o (q_flush),
      .we_o    (mem_we),
      .last_o  (last_wr),
      .done_o  (done),
      .idle_o  (idle)
   );

   irqstk_frame #(
      .SP_W   (SP_W),
      .BYTE_W (BYTE_W),
      .WORD_W (WORD_W),
      .SLOT_W (SLOT_W)
   ) u_frame (
      .clk     (clk),
      .rst     (rst),
      .capture (q_flush),
      .commit  (last_wr),
      .slot    (slot),
      .sp_i    (sp_i),
      .ret_i   (ret_i),
      .y_i     (idx_y_i),
      .x_i     (idx_x_i),
      .b_i     (acc_b_i),
      .a_i     (acc_a_i),
      .cond_i  (cond_i),
      .addr_o  (mem_addr),
      .data_o  (mem_wdata),
      .be_o    (mem_be),
      .sp_o    (sp_o)
   );

endmodule

// File: rtl/irqstk_chk.sv
module irqstk_chk
   import irqstk_pkg::*;
#(
   parameter int SP_W = 16
) (
   input logic            clk,
   input logic            rst,
   input logic            imask,
   input logic            eoi,
   input logic [SP_W-1:0] sp_i,
   input logic [SP_W-1:0] mem_addr,
   input logic [1:0]      mem_be,
   input logic            mem_we,
   input logic            q_flush,
   input logic [SP_W-1:0] sp_o,
   input logic            done,
   input stk_state_e      st
);

   logic [2:0]      wr_cnt;
   logic [SP_W-1:0] sp_snap;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_cnt  <= '0;
         sp_snap <= '0;
      end else if (q_flush) begin
         wr_cnt  <= '0;
         sp_snap <= sp_i;
      end else if (mem_we) begin
         wr_cnt  <= wr_cnt + 1'b1;
      end
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!mem_we && !q_flush && !done));

   a_r2_mask_keeps_idle: assert property (@(posedge clk) disable iff (rst)
      (st == ST_IDLE && imask) |=> (st == ST_IDLE));

   a_r3_wait_for_eoi: assert property (@(posedge clk) disable iff (rst)
      (st == ST_WAIT && !eoi) |=> !q_flush);

   a_r4_flush_then_write: assert property (@(posedge clk) disable iff (rst)
      q_flush |=> (mem_we && mem_addr == $past(sp_i) - SP_W'(2)));

   a_r5_first_word: assert property (@(posedge clk) disable iff (rst)
      q_flush |=> (mem_be == 2'b11));

   a_r8_byte_is_last: assert property (@(posedge clk) disable iff (rst)
      (mem_we && mem_be == 2'b10) |=> done);

   a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r10_sp_result: assert property (@(posedge clk) disable iff (rst)
      done |-> (sp_o == sp_snap - SP_W'(FRAME_BYTES)));

   a_r4_five_writes: assert property (@(posedge clk) disable iff (rst)
      done |-> (wr_cnt == 3'd5));

endmodule

bind irq_stacker irqstk_chk #(.SP_W(SP_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .imask    (imask),
   .eoi      (eoi),
   .sp_i     (sp_i),
   .mem_addr (mem_addr),
   .mem_be   (mem_be),
   .mem_we   (mem_we),
   .q_flush  (q_flush),
   .sp_o     (sp_o),
   .done     (done),
   .st       (st)
);

// File: tb/irq_stacker_test.sv
`timescale 1ns/1ps
module irq_stacker_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        irq_req = 1'b0, imask = 1'b0, eoi = 1'b0;
   logic [15:0] sp_i = '0, ret_i = '0, idx_y_i = '0, idx_x_i = '0;
   logic [7:0]  acc_b_i = '0, acc_a_i = '0, cond_i = '0;
   logic [15:0] mem_addr, mem_wdata, sp_o;
   logic [1:0]  mem_be;
   logic        mem_we, q_flush, done;

   always #2 clk = ~clk;

   irq_stacker uut (
      .clk(clk), .rst(rst), .irq_req(irq_req), .imask(imask), .eoi(eoi),
      .sp_i(sp_i), .ret_i(ret_i), .idx_y_i(idx_y_i), .idx_x_i(idx_x_i),
      .acc_b_i(acc_b_i), .acc_a_i(acc_a_i), .cond_i(cond_i),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_we(mem_we), .q_flush(q_flush), .sp_o(sp_o), .done(done)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   int          nflush, nwr, ndone;
   int          flush_c [16];
   int          wr_c    [16];
   logic [15:0] wr_a    [16];
   logic [15:0] wr_d    [16];
   logic [1:0]  wr_be   [16];
   int          done_c  [16];
   logic [15:0] done_sp [16];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // drive the scenario per cycle index and log what the outputs do
   task automatic run(input int ncyc, input int irq_a, input int irq_b,
                      input int eoi_a, input int eoi_b, input int eoi_c,
                      input int mask_until);
      nflush = 0; nwr = 0; ndone = 0;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         if (q_flush && nflush < 16) begin flush_c[nflush] = c; nflush++; end
         if (mem_we && nwr < 16) begin
            wr_c[nwr] = c; wr_a[nwr] = mem_addr; wr_d[nwr] = mem_wdata;
            wr_be[nwr] = mem_be; nwr++;
         end
         if (done && ndone < 16) begin
            done_c[ndone] = c; done_sp[ndone] = sp_o; ndone++;
         end
         irq_req = (c == irq_a) || (c == irq_b);
         eoi     = (c == eoi_a) || (c == eoi_b) || (c == eoi_c);
         imask   = (c < mask_until);
      end
      irq_req = 1'b0; eoi = 1'b0; imask = 1'b0;
   endtask

   task automatic set_regs(input logic [15:0] sp, input logic [15:0] ret,
                           input logic [15:0] y, input logic [15:0] x,
                           input logic [7:0] b, input logic [7:0] a,
                           input logic [7:0] cc);
      sp_i = sp; ret_i = ret; idx_y_i = y; idx_x_i = x;
      acc_b_i = b; acc_a_i = a; cond_i = cc;
   endtask

   task automatic check_frame(input int wi, input int fcyc);
      logic [15:0] ea [5];
      logic [15:0] ed [5];
      ea[0] = sp_i - 16'd2; ed[0] = ret_i;
      ea[1] = sp_i - 16'd4; ed[1] = idx_y_i;
      ea[2] = sp_i - 16'd6; ed[2] = idx_x_i;
      ea[3] = sp_i - 16'd8; ed[3] = {acc_b_i, acc_a_i};
      ea[4] = sp_i - 16'd9; ed[4] = {cond_i, 8'h00};
      for (int k = 0; k < 5; k++) begin
         chk(wr_c[wi+k] == fcyc + 1 + k, "R4", "write cycle", wr_c[wi+k], fcyc + 1 + k);
      end
      chk(wr_a[wi] == ea[0] && wr_d[wi] == ed[0] && wr_be[wi] == 2'b11,
          "R5", "return word", {wr_a[wi], wr_d[wi]}, {ea[0], ed[0]});
      chk(wr_a[wi+1] == ea[1] && wr_d[wi+1] == ed[1] && wr_be[wi+1] == 2'b11,
          "R6", "Y word", {wr_a[wi+1], wr_d[wi+1]}, {ea[1], ed[1]});
      chk(wr_a[wi+2] == ea[2] && wr_d[wi+2] == ed[2] && wr_be[wi+2] == 2'b11,
          "R6", "X word", {wr_a[wi+2], wr_d[wi+2]}, {ea[2], ed[2]});
      chk(wr_a[wi+3] == ea[3] && wr_d[wi+3] == ed[3] && wr_be[wi+3] == 2'b11,
          "R7", "B:A pair", {wr_a[wi+3], wr_d[wi+3]}, {ea[3], ed[3]});
      chk(wr_a[wi+4] == ea[4] && wr_d[wi+4][15:8] == cond_i && wr_be[wi+4] == 2'b10,
          "R8", "cond byte", {wr_a[wi+4], wr_d[wi+4][15:8], 6'd0, wr_be[wi+4]},
          {ea[4], cond_i, 8'h02});
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!mem_we && !q_flush && !done, "R1", "strobes after reset",
          {mem_we, q_flush, done}, 0);
      chk(sp_o == 16'h0, "R1", "sp_o after reset", sp_o, 0);
   endtask

   task automatic t_basic;
      set_regs(16'h0C00, 16'h8123, 16'hA1B2, 16'hC3D4, 8'h5E, 8'h6F, 8'hD0);
      run(20, 2, -1, 5, -1, -1, 0);
      chk(nflush == 1 && flush_c[0] == 6, "R3", "flush one cycle after eoi",
          flush_c[0], 6);
      chk(nwr == 5, "R4", "write count", nwr, 5);
      check_frame(0, 6);
      chk(ndone == 1 && done_c[0] == 12, "R10", "done cycle", done_c[0], 12);
      chk(done_sp[0] == 16'h0BF7, "R10", "sp at done", done_sp[0], 16'h0BF7);
      chk(sp_o == 16'h0BF7, "R10", "sp held", sp_o, 16'h0BF7);
   endtask

   task automatic t_wrap_same_cycle;
      set_regs(16'h0005, 16'h4455, 16'h0102, 16'hFEDC, 8'h33, 8'h44, 8'h81);
      run(16, 2, -1, 2, -1, -1, 0);
      chk(nflush == 1 && flush_c[0] == 3, "R12", "flush after joint accept+eoi",
          flush_c[0], 3);
      chk(nwr == 5, "R9", "write count", nwr, 5);
      check_frame(0, 3);
      chk(wr_a[4] == 16'hFFFC, "R9", "wrapped cond address", wr_a[4], 16'hFFFC);
      chk(ndone == 1 && done_sp[0] == 16'hFFFC, "R9", "wrapped sp", done_sp[0], 16'hFFFC);
   endtask

   task automatic t_masked;
      set_regs(16'h2000, 16'h1357, 16'h2468, 16'h9ABC, 8'h11, 8'h22, 8'h0F);
      run(30, 2, -1, 5, 14, -1, 12);
      chk(nflush == 1 && flush_c[0] == 15, "R2", "flush only after mask clear and eoi",
          flush_c[0], 15);
      chk(nwr == 5 && wr_c[0] == 16, "R2", "no write while masked", wr_c[0], 16);
      check_frame(0, 15);
      chk(ndone == 1 && done_c[0] == 21, "R10", "done cycle", done_c[0], 21);
   endtask

   task automatic t_during;
      set_regs(16'h0900, 16'hBEEF, 16'h0F0F, 16'hF0F0, 8'hAA, 8'h55, 8'h3C);
      run(35, 2, 7, 3, 8, 14, 0);
      chk(nflush == 2 && flush_c[0] == 4, "R11", "first flush", flush_c[0], 4);
      chk(flush_c[1] == 15, "R11", "deferred flush after done and new eoi",
          flush_c[1], 15);
      chk(ndone == 2 && done_c[0] == 10 && done_c[1] == 21, "R11", "two dones",
          done_c[1], 21);
      chk(nwr == 10, "R11", "write count", nwr, 10);
      check_frame(0, 4);
      check_frame(5, 15);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      t_reset();
      t_basic();
      t_wrap_same_cycle();
      t_masked();
      t_during();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule